// File: doc/BRIEF.md
# Multichannel Edge Timestamp Recorder

This block watches a bank of single-bit comparator lines (44 by default, two thresholds for each of 22 optical sensors) and logs every settled level change as a timestamped record. Each line is synchronised with two flops and then passes through a small per-channel state machine. The state machine accepts a new level only after the synchronised line has held it for three consecutive samples. When a change is accepted, the channel raises a one-deep pending slot. The slot holds the edge direction and the timestamp of the first sample that showed the new level. The timestamp comes from a free-running 32-bit counter that wraps.

A round-robin arbiter moves one pending slot per clock into a 64-entry FIFO. Edges that occur on many channels in the same cycle are therefore all kept, and they all carry the same timestamp. An external microcontroller drains the FIFO at its own pace through a pop strobe. The head record is visible on the data output while the pop is asserted. An interrupt line stays high while records are waiting. A write that arrives while the FIFO is full is dropped and sets a sticky overflow flag, which only an explicit clear input resets.

Per-channel filter states and transitions:
- `ST_LOW` to `ST_RISE_CHK` when the synchronised line reads 1. This step latches the timestamp.
- `ST_RISE_CHK` to `ST_LOW` if the line reads 0 before three samples have been seen.
- `ST_RISE_CHK` to `ST_HIGH` on the third consecutive 1, once the channel's pending slot is free. This step emits a rising event.
- `ST_HIGH` to `ST_FALL_CHK` when the line reads 0. This step latches the timestamp.
- `ST_FALL_CHK` to `ST_HIGH` if the line reads 1 again.
- `ST_FALL_CHK` to `ST_LOW` on the third consecutive 0, once the slot is free. This step emits a falling event.

Top module: `edge_stamp_recorder`

## Requirements
- R1: A level change on a comparator line produces exactly one record, and only after the synchronised line has held the new level for 3 consecutive samples. A pulse of 1 or 2 cycles produces no record. A pulse of exactly 3 cycles produces one rising record and one falling record.
- R2: Each record is 39 bits wide. Bit 0 is the direction (1 = rising, 0 = falling). Bits [6:1] hold the channel number (0 to 43). Bits [38:7] hold the timestamp.
- R3: The difference between the timestamps of two records equals the number of clock cycles between the two raw input changes. The timestamp counter is free-running and wraps modulo 2^32.
- R4: When several channels change in the same cycle, every channel gets exactly one record and all of those records carry the same timestamp. The round-robin arbiter writes at most one record per cycle and grants only channels whose slot is pending.
- R5: The FIFO holds up to 64 records. `rd_data` shows the oldest record before and during the cycle in which `rd_pop` is high, and the pop removes it. A pop while `rd_empty` is 1 has no effect.
- R6: A record written while the FIFO holds 64 entries is discarded, and the earlier contents are kept. The discard sets `ovf_flag`, which stays at 1 through pops until `ovf_clr` is pulsed. If a discard and `ovf_clr` occur in the same cycle, the flag is set.
- R7: `evt_irq` is 1 exactly while the FIFO holds at least one record, that is, while `rd_empty` is 0.
- R8: Active-low `rst_n` clears the timestamp counter, all filters, all pending slots, the FIFO and the overflow flag. After reset, `rd_empty` is 1, `evt_irq` is 0 and `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, at least 10 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | N_CH (44) | Asynchronous comparator lines, one bit per channel |
| rd_pop | input | 1 | Removes the head record of the FIFO |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| rd_data | output | TS_W+clog2(N_CH)+1 (39) | Head record: {timestamp, channel, direction} |
| rd_empty | output | 1 | FIFO holds no record |
| evt_irq | output | 1 | Interrupt: records are waiting |
| ovf_flag | output | 1 | Sticky flag: a record was discarded |

## Verification
A filter state machine left in the wrong state shows up as a missing or duplicated record within about six cycles of a raw change. The record might carry the wrong direction bit, or the FIFO might not be empty after a single pop. A timestamp latched at the wrong step, or a counter that stalls, makes the difference between the timestamps of two records drift from the cycle count between the raw changes. This is visible in the first pair of records read out. A pending slot that is lost or never cleared in the arbiter shows up when 44 simultaneous edges are drained: a channel is missing or repeated, or the record count is not 44. A FIFO pointer or count fault shows up as a record count other than 64 after an overrun, as wrong direction bits among the kept records, or as an `ovf_flag` that does not stay set.

// File: rtl/edge_rec_pkg.sv
package edge_rec_pkg;
    typedef enum logic [1:0] {
        ST_LOW,
        ST_RISE_CHK,
        ST_HIGH,
        ST_FALL_CHK
    } flt_state_e;
endpackage

// File: rtl/edge_chan_filter.sv
module edge_chan_filter
    import edge_rec_pkg::*;
#(
    parameter int TS_W     = 32,
    parameter int FILT_CYC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_in,
    input  logic [TS_W-1:0] ts_now,
    input  logic            grant,
    output logic            pend,
    output logic            pend_dir,
    output logic [TS_W-1:0] pend_ts
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYC - 1);

    logic             sync1_q, sync2_q;
    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TS_W-1:0]  cap_q, cap_d;
    logic             fire, fire_dir;

    // two-flop synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= raw_in;
            sync2_q <= sync1_q;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
            cnt_q   <= '0;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cap_q   <= cap_d;
        end
    end

    // next state and event outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        cap_d    = cap_q;
        fire     = 1'b0;
        fire_dir = 1'b0;
        unique case (state_q)
            ST_LOW: begin
                if (sync2_q) begin
                    state_d = ST_RISE_CHK;
                    cnt_d   = CNT_W'(1);
                    cap_d   = ts_now;
                end
            end
            ST_RISE_CHK: begin
                if (!sync2_q) begin
                    state_d = ST_LOW;
                end else if (cnt_q == LAST) begin
                    if (!pend) begin
                        fire     = 1'b1;
                        fire_dir = 1'b1;
                        state_d  = ST_HIGH;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (!sync2_q) begin
                    state_d = ST_FALL_CHK;
                    cnt_d   = CNT_W'(1);
                    cap_d   = ts_now;
                end
            end
            ST_FALL_CHK: begin
                if (sync2_q) begin
                    state_d = ST_HIGH;
                end else if (cnt_q == LAST) begin
                    if (!pend) begin
                        fire     = 1'b1;
                        fire_dir = 1'b0;
                        state_d  = ST_LOW;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = ST_LOW;
        endcase
    end

    // one-deep pending slot, released by the arbiter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_dir <= 1'b0;
            pend_ts  <= '0;
        end else if (fire) begin
            pend     <= 1'b1;
            pend_dir <= fire_dir;
            pend_ts  <= cap_q;
        end else if (grant) begin
            pend     <= 1'b0;
        end
    end
endmodule

// File: rtl/edge_rr_arb.sv
module edge_rr_arb #(
    parameter int N    = 44,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    output logic [N-1:0]    grant,
    output logic [IDXW-1:0] gnt_idx,
    output logic            gnt_any
);
    logic [IDXW-1:0] last_q;

    always_comb begin
        int c;
        grant   = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = 0; i < N; i++) begin
            c = int'(last_q) + 1 + i;
            if (c >= N) c = c - N;
            if (!gnt_any && req[c]) begin
                gnt_any  = 1'b1;
                grant[c] = 1'b1;
                gnt_idx  = IDXW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= IDXW'(N - 1);
        else if (gnt_any) last_q <= gnt_idx;
    end
endmodule

// File: rtl/edge_fifo.sv
module edge_fifo #(
    parameter int W     = 39,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         drop,
    output logic [AW:0]  count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          full, do_push, do_pop;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + AW'(1);
            if (do_pop)  rp_q <= rp_q + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
                2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end
endmodule

// File: rtl/edge_stamp_recorder.sv
module edge_stamp_recorder #(
    parameter int N_CH       = 44,
    parameter int TS_W       = 32,
    parameter int FIFO_DEPTH = 64,
    parameter int FILT_CYC   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CH-1:0]             cmp_in,
    input  logic                        rd_pop,
    input  logic                        ovf_clr,
    output logic [TS_W+$clog2(N_CH):0]  rd_data,
    output logic                        rd_empty,
    output logic                        evt_irq,
    output logic                        ovf_flag
);
    localparam int CH_W  = $clog2(N_CH);
    localparam int REC_W = TS_W + CH_W + 1;
    localparam int AW    = $clog2(FIFO_DEPTH);

    logic [TS_W-1:0] ts_q;
    logic [N_CH-1:0] ch_pend, ch_grant, ch_dir;
    logic [TS_W-1:0] ch_ts [N_CH];
    logic [CH_W-1:0] gnt_idx;
    logic            gnt_any;
    logic [REC_W-1:0] rec;
    logic            fifo_drop;
    logic [AW:0]     fifo_cnt;

    // free-running timestamp, wraps
    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + TS_W'(1);
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        edge_chan_filter #(.TS_W(TS_W), .FILT_CYC(FILT_CYC)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (cmp_in[g]),
            .ts_now   (ts_q),
            .grant    (ch_grant[g]),
            .pend     (ch_pend[g]),
            .pend_dir (ch_dir[g]),
            .pend_ts  (ch_ts[g])
        );
    end

    edge_rr_arb #(.N(N_CH), .IDXW(CH_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ch_pend),
        .grant   (ch_grant),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    assign rec = {ch_ts[gnt_idx], gnt_idx, ch_dir[gnt_idx]};

    edge_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH), .AW(AW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (gnt_any),
        .din   (rec),
        .pop   (rd_pop),
        .dout  (rd_data),
        .empty (rd_empty),
        .drop  (fifo_drop),
        .count (fifo_cnt)
    );

    assign evt_irq = !rd_empty;

    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_flag <= 1'b0;
        else if (fifo_drop) ovf_flag <= 1'b1;
        else if (ovf_clr)   ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/edge_stamp_checker.sv
module edge_stamp_checker #(
    parameter int N_CH       = 44,
    parameter int FIFO_DEPTH = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rd_pop,
    input logic                        ovf_clr,
    input logic                        evt_irq,
    input logic                        ovf_flag,
    input logic [N_CH-1:0]             ch_pend,
    input logic [N_CH-1:0]             ch_grant,
    input logic [$clog2(FIFO_DEPTH):0] fifo_cnt,
    input logic                        fifo_push
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_grant));

    p_grant_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_grant & ~ch_pend) == '0);

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(FIFO_DEPTH));

    p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0 && rd_pop && !fifo_push) |=> fifo_cnt == '0);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CW'(FIFO_DEPTH) && fifo_push) |=> ovf_flag);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_irq) |-> $past(rd_pop));
endmodule

bind edge_stamp_recorder edge_stamp_checker #(
    .N_CH       (N_CH),
    .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pop    (rd_pop),
    .ovf_clr   (ovf_clr),
    .evt_irq   (evt_irq),
    .ovf_flag  (ovf_flag),
    .ch_pend   (ch_pend),
    .ch_grant  (ch_grant),
    .fifo_cnt  (fifo_cnt),
    .fifo_push (gnt_any)
);

// File: tb/tb_edge_stamp_recorder.sv
module tb_edge_stamp_recorder;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 44;

    // table: {level, channel}; each row is one isolated edge, 9 cycles apart
    localparam logic [6:0] VEC [8] = '{
        {1'b1, 6'd0},  {1'b1, 6'd43}, {1'b1, 6'd5},  {1'b0, 6'd0},
        {1'b1, 6'd22}, {1'b0, 6'd43}, {1'b0, 6'd5},  {1'b0, 6'd22}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NCH-1:0]  cmp_in;
    logic            rd_pop;
    logic            ovf_clr;
    logic [38:0]     rd_data;
    logic            rd_empty, evt_irq, ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0]    prev_ts, t0;
    logic [5:0]     vch;
    logic           vlv;
    int             n_rec, n_fall, n_tsbad;
    logic [NCH-1:0] seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_stamp_recorder dut (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .rd_pop(rd_pop),
        .ovf_clr(ovf_clr), .rd_data(rd_data), .rd_empty(rd_empty),
        .evt_irq(evt_irq), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    // drain everything, counting records, falling edges, channels and ts mismatches
    task automatic drain();
        logic [31:0] first_ts;
        n_rec = 0; n_fall = 0; n_tsbad = 0; seen = '0; first_ts = '0;
        while (!rd_empty && n_rec < 200) begin
            if (n_rec == 0) first_ts = rd_data[38:7];
            else if (rd_data[38:7] != first_ts) n_tsbad++;
            if (!rd_data[0]) n_fall++;
            seen[rd_data[6:1]] = 1'b1;
            n_rec++;
            pop_one();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmp_in = '0; rd_pop = 1'b0; ovf_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk(rd_empty == 1'b1, "R8", "empty after reset", rd_empty, 1);
        chk(evt_irq == 1'b0, "R8", "irq after reset", evt_irq, 0);
        chk(ovf_flag == 1'b0, "R8", "overflow after reset", ovf_flag, 0);

        // table walk: R1, R2, R3, R5, R7
        prev_ts = '0;
        for (int i = 0; i < 8; i++) begin
            vlv = VEC[i][6];
            vch = VEC[i][5:0];
            cmp_in[vch] = vlv;
            repeat (8) @(negedge clk);
            chk(evt_irq == 1'b1, "R7", "irq with record waiting", evt_irq, 1);
            chk(rd_data[6:1] == vch, "R2", "channel field", rd_data[6:1], vch);
            chk(rd_data[0] == vlv, "R2", "direction bit", rd_data[0], vlv);
            if (i > 0)
                chk(rd_data[38:7] - prev_ts == 32'd9, "R3", "timestamp step",
                    rd_data[38:7] - prev_ts, 9);
            prev_ts = rd_data[38:7];
            pop_one();
            chk(rd_empty == 1'b1, "R1", "one record per edge", rd_empty, 1);
            chk(evt_irq == 1'b0, "R7", "irq after pop", evt_irq, 0);
        end

        // R1 glitch rejection: 1-cycle and 2-cycle pulses on channel 7
        cmp_in[7] = 1'b1; @(negedge clk); cmp_in[7] = 1'b0;
        repeat (10) @(negedge clk);
        cmp_in[7] = 1'b1; repeat (2) @(negedge clk); cmp_in[7] = 1'b0;
        repeat (12) @(negedge clk);
        chk(rd_empty == 1'b1, "R1", "short pulses ignored", rd_empty, 1);

        // R1/R3 exactly 3-cycle pulse on channel 9 qualifies both edges
        cmp_in[9] = 1'b1; repeat (3) @(negedge clk); cmp_in[9] = 1'b0;
        repeat (12) @(negedge clk);
        chk(rd_data[6:0] == {6'd9, 1'b1}, "R1", "3-cycle rise record", rd_data[6:0], {6'd9, 1'b1});
        t0 = rd_data[38:7];
        pop_one();
        chk(rd_data[6:0] == {6'd9, 1'b0}, "R1", "3-cycle fall record", rd_data[6:0], {6'd9, 1'b0});
        chk(rd_data[38:7] - t0 == 32'd3, "R3", "pulse width in timestamps", rd_data[38:7] - t0, 3);
        pop_one();
        chk(rd_empty == 1'b1, "R5", "empty after two pops", rd_empty, 1);

        // R4 all channels rise together
        cmp_in = '1;
        repeat (70) @(negedge clk);
        drain();
        chk(n_rec == NCH, "R4", "records for simultaneous edges", n_rec, NCH);
        chk(seen == '1, "R4", "every channel present", $countones(seen), NCH);
        chk(n_tsbad == 0, "R4", "records with differing timestamp", n_tsbad, 0);
        chk(n_fall == 0, "R4", "falling records in rise burst", n_fall, 0);

        // R5 pop on empty has no effect
        pop_one();
        chk(rd_empty == 1'b1, "R5", "pop when empty", rd_empty, 1);

        // R6 overrun: 44 falls then 44 rises without reading
        cmp_in = '0;
        repeat (70) @(negedge clk);
        cmp_in = '1;
        repeat (70) @(negedge clk);
        chk(ovf_flag == 1'b1, "R6", "overflow set", ovf_flag, 1);
        chk(evt_irq == 1'b1, "R7", "irq while full", evt_irq, 1);
        drain();
        chk(n_rec == 64, "R5", "FIFO depth", n_rec, 64);
        chk(n_fall == NCH, "R6", "earliest records kept", n_fall, NCH);
        chk(ovf_flag == 1'b1, "R6", "overflow sticky through pops", ovf_flag, 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R6", "overflow cleared", ovf_flag, 0);

        // R8 reset mid-operation clears a queued record
        cmp_in[3] = 1'b0;
        repeat (8) @(negedge clk);
        chk(rd_empty == 1'b0, "R8", "record queued before reset", rd_empty, 0);
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(rd_empty == 1'b1, "R8", "FIFO cleared by reset", rd_empty, 1);
        chk(ovf_flag == 1'b0, "R8", "overflow cleared by reset", ovf_flag, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule